// File: doc/BRIEF.md
# Accumulator Processor Core

A small multi-cycle processor built around a single 16-bit accumulator. Every instruction is one 16-bit word: the upper four bits select the operation and the lower twelve bits give either a memory address or an I/O port number. The core reads instructions and data from one synchronous memory. That memory returns read data one clock after the address is presented and writes on a clock edge when write-enable is high.

Each instruction takes three clock cycles: fetch, decode and execute. Instructions that read a data word (load, add, subtract, compare) take a fourth cycle, in which the returned word is consumed. A compare sets greater, equal and less flags, and three conditional jumps test them. A fourth conditional jump tests the accumulator sign bit. Input and output use one bus each, and each bus has a one-cycle strobe and a port number. A halt instruction stops the core until reset.

Top module: `acc_core`

## Requirements
- R1: The instruction word carries the opcode in bits [15:12] and the operand in bits [11:0]. The codes are 0 no-op, 1 load, 2 store, 3 add, 4 subtract, 5 input, 6 output, 7 jump, 8 jump-if-negative, 9 halt, A compare, B jump-if-greater, C jump-if-equal and D jump-if-less. A load places the memory word at the operand address in the accumulator.
- R2: Add and subtract combine the accumulator with the memory word at the operand address, and the 16-bit result wraps modulo 2^16.
- R3: A store writes the accumulator to the operand address, with write-enable high for exactly one cycle.
- R4: Input copies `in_data` into the accumulator. It drives the operand on `in_port` and raises `in_strobe` for exactly one cycle.
- R5: Output drives the accumulator on `out_data` and the operand on `out_port`, and raises `out_strobe` for exactly one cycle.
- R6: Compare treats the accumulator and the memory word as signed 16-bit values and records greater, equal or less. The accumulator is left unchanged.
- R7: Jump-if-greater, jump-if-equal and jump-if-less go to the operand address when the matching flag from the latest compare is set. Otherwise execution continues at the next word.
- R8: Jump always loads the operand into the program counter. Jump-if-negative does so only when accumulator bit 15 is 1.
- R9: Halt raises `halted`. The core then does no memory writes and no strobes until reset.
- R10: Code 0 and codes E and F change no state.
- R11: After reset the program counter and the accumulator are 0 and `halted` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | output | 12 | Memory address |
| mem_wdata | output | 16 | Memory write data (accumulator) |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 16 | Memory read data, valid one cycle after the address |
| in_data | input | 16 | Input bus |
| in_port | output | 12 | Port number of an input |
| in_strobe | output | 1 | One-cycle input strobe |
| out_data | output | 16 | Output bus |
| out_port | output | 12 | Port number of an output |
| out_strobe | output | 1 | One-cycle output strobe |
| halted | output | 1 | Core has stopped |

## Verification
The accumulator and the flags can only be seen through output instructions. A corrupted accumulator therefore shows up at the next output, a few cycles later, as a wrong value on `out_data`. Wrong flags or a wrong program counter send execution down the wrong path. That path is marked by a distinct constant being output, or by outputs that are missing or unexpected before `halted` rises. Programs built from random operands therefore compare the whole sequence of outputs and its length against values computed in the bench.

// File: rtl/acc_core.sv
module acc_core #(
  parameter int DW = 16,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  input  logic [DW-1:0] mem_rdata,
  input  logic [DW-1:0] in_data,
  output logic [AW-1:0] in_port,
  output logic          in_strobe,
  output logic [DW-1:0] out_data,
  output logic [AW-1:0] out_port,
  output logic          out_strobe,
  output logic          halted
);
  localparam int IW = AW + 4;

  typedef enum logic [2:0] {S_FETCH, S_DECODE, S_EXEC, S_MEM, S_HALT} state_t;

  state_t        state;
  logic [AW-1:0] pc;
  logic [DW-1:0] acc;
  logic [IW-1:0] ir;
  logic          f_gt, f_eq, f_lt;

  logic [3:0]    op;
  logic [AW-1:0] opnd;
  logic          in_exec;

  assign op      = ir[IW-1:AW];
  assign opnd    = ir[AW-1:0];
  assign in_exec = (state == S_EXEC);

  assign mem_addr   = (state == S_FETCH || state == S_DECODE) ? pc : opnd;
  assign mem_wdata  = acc;
  assign mem_we     = in_exec && op == 4'h2;
  assign in_port    = opnd;
  assign in_strobe  = in_exec && op == 4'h5;
  assign out_data   = acc;
  assign out_port   = opnd;
  assign out_strobe = in_exec && op == 4'h6;
  assign halted     = (state == S_HALT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_FETCH;
      pc    <= '0;
      acc   <= '0;
      ir    <= '0;
      f_gt  <= 1'b0;
      f_eq  <= 1'b0;
      f_lt  <= 1'b0;
    end else begin
      case (state)
        S_FETCH: state <= S_DECODE;
        S_DECODE: begin
          ir    <= mem_rdata[IW-1:0];
          pc    <= pc + 1'b1;
          state <= S_EXEC;
        end
        S_EXEC: begin
          state <= S_FETCH;
          case (op)
            4'h1, 4'h3, 4'h4, 4'hA: state <= S_MEM;
            4'h5: acc <= in_data;
            4'h7: pc <= opnd;
            4'h8: if (acc[DW-1]) pc <= opnd;
            4'h9: state <= S_HALT;
            4'hB: if (f_gt) pc <= opnd;
            4'hC: if (f_eq) pc <= opnd;
            4'hD: if (f_lt) pc <= opnd;
            default: ;
          endcase
        end
        S_MEM: begin
          state <= S_FETCH;
          case (op)
            4'h1: acc <= mem_rdata;
            4'h3: acc <= acc + mem_rdata;
            4'h4: acc <= acc - mem_rdata;
            default: begin
              f_gt <= $signed(acc) >  $signed(mem_rdata);
              f_eq <= acc == mem_rdata;
              f_lt <= $signed(acc) <  $signed(mem_rdata);
            end
          endcase
        end
        default: state <= S_HALT;
      endcase
    end
  end
endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk (
  input logic clk,
  input logic rst_n,
  input logic mem_we,
  input logic in_strobe,
  input logic out_strobe,
  input logic halted
);
  a_r9_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);
  a_r9_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_we && !in_strobe && !out_strobe);
  a_r3_we_single: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);
  a_r4_in_single: assert property (@(posedge clk) disable iff (!rst_n)
    in_strobe |=> !in_strobe);
  a_r5_out_single: assert property (@(posedge clk) disable iff (!rst_n)
    out_strobe |=> !out_strobe);
  a_r1_one_action: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_we, in_strobe, out_strobe}));
endmodule

bind acc_core acc_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mem_we(mem_we),
  .in_strobe(in_strobe), .out_strobe(out_strobe), .halted(halted)
);

// File: tb/tb_acc_core.sv
module tb_acc_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] mem_addr, in_port, out_port;
  logic [15:0] mem_wdata, mem_rdata, in_data, out_data;
  logic        mem_we, in_strobe, out_strobe, halted;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  acc_core dut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .in_data(in_data),
    .in_port(in_port), .in_strobe(in_strobe), .out_data(out_data),
    .out_port(out_port), .out_strobe(out_strobe), .halted(halted)
  );

  logic [15:0] mem [256];
  logic        ld_en = 1'b0;
  logic [7:0]  ld_a = '0;
  logic [15:0] ld_d = '0;

  always @(posedge clk) begin
    if (ld_en) mem[ld_a] <= ld_d;
    else if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[7:0]];
  end

  logic        clr = 1'b0;
  int          n_out, n_in;
  logic [11:0] cap_port [16];
  logic [15:0] cap_data [16];
  logic [11:0] last_in_port;

  always @(negedge clk) begin
    if (clr) begin
      n_out <= 0;
      n_in  <= 0;
    end else begin
      if (out_strobe && n_out < 16) begin
        cap_port[n_out] <= out_port;
        cap_data[n_out] <= out_data;
        n_out <= n_out + 1;
      end
      if (in_strobe) begin
        n_in <= n_in + 1;
        last_in_port <= in_port;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic ld(input int a, input logic [15:0] d);
    @(negedge clk);
    ld_en = 1'b1;
    ld_a  = 8'(a);
    ld_d  = d;
  endtask

  task automatic start();
    @(negedge clk);
    ld_en = 1'b0;
    check("R11 reset not halted", 32'(halted), 0);
    check("R11 reset pc", 32'(mem_addr), 0);
    clr = 1'b0;
    rst_n = 1'b1;
    for (int i = 0; i < 3000 && !halted; i++) @(negedge clk);
    repeat (30) @(negedge clk);
    check("R9 halted", 32'(halted), 1);
  endtask

  task automatic prep();
    @(negedge clk);
    rst_n = 1'b0;
    clr = 1'b1;
    @(negedge clk);
  endtask

  function automatic logic [15:0] cmp_code(input logic [15:0] x, input logic [15:0] y);
    if ($signed(x) > $signed(y)) return 16'd1;
    if (x == y) return 16'd2;
    return 16'd3;
  endfunction

  task automatic arith_prog(input logic [15:0] a, input logic [15:0] b);
    logic [15:0] diff;
    diff = a - b;
    prep();
    ld(0, 16'h1064); ld(1, 16'h3065); ld(2, 16'h6005); ld(3, 16'h1064);
    ld(4, 16'h4065); ld(5, 16'h6006); ld(6, 16'hA065); ld(7, 16'h6008);
    ld(8, 16'hB014); ld(9, 16'hC017); ld(10, 16'hD01A); ld(11, 16'h9000);
    ld(20, 16'h106E); ld(21, 16'h6007); ld(22, 16'h701E);
    ld(23, 16'h106F); ld(24, 16'h6007); ld(25, 16'h701E);
    ld(26, 16'h1070); ld(27, 16'h6007); ld(28, 16'h701E);
    ld(30, 16'h1065); ld(31, 16'h8028);
    ld(32, 16'h1071); ld(33, 16'h6009); ld(34, 16'h9000);
    ld(40, 16'h1072); ld(41, 16'h6009); ld(42, 16'h9000);
    ld(100, a); ld(101, b);
    ld(110, 16'd1); ld(111, 16'd2); ld(112, 16'd3); ld(113, 16'd4); ld(114, 16'd5);
    start();
    check("R5 output count", 32'(n_out), 5);
    check("R2 add port", 32'(cap_port[0]), 5);
    check("R2 add wraps", 32'(cap_data[0]), 32'(16'(a + b)));
    check("R2 sub wraps", 32'(cap_data[1]), 32'(diff));
    check("R6 cmp keeps acc", 32'(cap_data[2]), 32'(diff));
    check("R7 branch on flags", 32'(cap_data[3]), 32'(cmp_code(diff, b)));
    check("R8 jn on sign", 32'(cap_data[4]), b[15] ? 32'd5 : 32'd4);
  endtask

  initial begin
    void'($urandom(32'd1234));
    in_data = 16'h0;

    prep();
    in_data = 16'hBEEF;
    ld(0, 16'h6002); ld(1, 16'h5003); ld(2, 16'h2078); ld(3, 16'h0000);
    ld(4, 16'hE000); ld(5, 16'hF123); ld(6, 16'h6004); ld(7, 16'h1078);
    ld(8, 16'h6005); ld(9, 16'h9000); ld(10, 16'h6001); ld(120, 16'h1111);
    start();
    check("R11 acc zero after reset", 32'(cap_data[0]), 0);
    check("R5 out port", 32'(cap_port[0]), 2);
    check("R4 input strobes once", 32'(n_in), 1);
    check("R4 input port", 32'(last_in_port), 3);
    check("R10 no-op codes keep acc", 32'(cap_data[1]), 32'hBEEF);
    check("R3 stored word read back", 32'(cap_data[2]), 32'hBEEF);
    check("R1 load from operand", 32'(cap_port[2]), 5);
    check("R9 nothing after halt", 32'(n_out), 3);
    check("R9 halted without write", 32'(mem_we), 0);

    arith_prog(16'h1234, 16'h1234);
    arith_prog(16'hFFFF, 16'h0001);
    arith_prog(16'h8000, 16'h0001);
    arith_prog(16'h0000, 16'h8000);
    arith_prog(16'h7FFF, 16'hFFFF);
    for (int k = 0; k < 12; k++) begin
      logic [15:0] ra, rb;
      ra = 16'($urandom);
      rb = (k % 4 == 0) ? ra / 16'd2 : 16'($urandom);
      arith_prog(ra, rb);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule